// File: doc/BRIEF.md
# Cone-Tree Window Scheduling Controller

This block sequences a tree of multi-iteration stencil cones so that a frame is processed the full iteration count deep, one output window at a time. Each cone advances its input by a fixed number of iterations. The tree therefore has H = N_ITER / CONE_DEPTH levels. Level 0 has H leaf cones. Each higher level has one cone fewer, and each parent reads the results of two neighbouring children. The cone arithmetic lives outside the block. The controller only decides when each cone slot starts and which on-chip buffer regions it reads and writes.

For every output-window position the controller works through three phases. First it fetches a square input chunk from external memory into the input slot of the on-chip buffer. The chunk is widened by a halo, and coordinates outside the frame are clamped to the border. Next it starts the cones one at a time in a dependency-respecting order. Each cone result is parked in a buffer slot of its own, so a result needed by two parents is produced once and read twice. Finally it streams the top cone's window back to external memory. The window then steps by its own size in raster order, and windows at the right and bottom edges shrink to fit the frame.

Top module: `cone_tree_ctrl`

## Requirements
- R1: While reset is high and after its release, busy, done, mem_req, cone_start and cone_busy are all low.
- R2: A start seen while busy is low raises busy in the next cycle. A start seen while busy is high is ignored: the transaction and cone streams of the running frame are unchanged and no extra frame follows.
- R3: Window origins step by WIN in raster order (x first, then y). An edge window is clamped to min(WIN, FRAME_W-x0) columns by min(WIN, FRAME_H-y0) rows, so every output pixel of the frame is written exactly once.
- R4: Each window begins with IN_SIDE*IN_SIDE reads, where IN_SIDE = WIN+2*HALO, issued in row-major order. The address of beat (r,c) is IN_BASE + gy*FRAME_W + gx, with gx = clamp(x0-HALO+c, 0, FRAME_W-1) and gy = clamp(y0-HALO+r, 0, FRAME_H-1). On each granted read, buf_we is high and buf_addr = r*IN_SIDE+c.
- R5: Once mem_req is raised, it holds with mem_addr and mem_we stable until a cycle in which mem_gnt is high. That cycle completes the beat.
- R6: Cones are started one at a time with a single-cycle one-hot cone_start (bit k-1 for cone k). The next cone starts only after the current one has signalled done. The order follows the leaves left to right, and each leaf is followed by every parent it completes. For three levels this order is 1, 2, 4, 3, 5, 6. No cone starts while an external transfer is in progress.
- R7: A parent cone is started only after both of its children have signalled done in the same window. For three levels the children are 4←(1,2), 5←(2,3) and 6←(4,5).
- R8: Cone k writes buffer slot k at base k*SLOT_WORDS, with SLOT_WORDS = IN_SIDE*IN_SIDE. A parent's two source addresses are its children's slot bases. Leaf p (0-based position) reads slot 0 at offset p*LEAF_OFS on both sources. Each cone, the shared one included, is started exactly once per window.
- R9: After the top cone is done, the window's clamped columns×rows are written in row-major order. The address is OUT_BASE + (y0+r)*FRAME_W + x0+c, buf_re is high and buf_addr = NUM_CONES*SLOT_WORDS + r*WIN + c.
- R10: After the grant of the frame's final write, done is high for exactly one cycle, in the following cycle. In that same cycle busy is low.
- R11: cone_busy[k-1] is high from the cycle in which cone k is started through the cycle in which its cone_done arrives, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Frame start request |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle frame completion pulse |
| mem_req | output | 1 | External memory request |
| mem_we | output | 1 | External request is a write |
| mem_addr | output | AW | External word address |
| mem_gnt | input | 1 | External memory accepts the current beat |
| buf_we | output | 1 | On-chip buffer write (granted fetch beat) |
| buf_re | output | 1 | On-chip buffer read (writeback beat) |
| buf_addr | output | BAW | On-chip buffer word address |
| cone_start | output | NUM_CONES | One-hot cone start pulse |
| cone_busy | output | NUM_CONES | Cone slot running |
| cone_done | input | NUM_CONES | Cone slot finished pulse |
| cone_src0_addr | output | BAW | First source region of the started cone |
| cone_src1_addr | output | BAW | Second source region of the started cone |
| cone_dst_addr | output | BAW | Destination region of the started cone |

## Verification
Two of the controller's functions can fall in the same cycle: the one-cycle frame-done pulse and the acceptance of a new start. The bench raises start in exactly the cycle where done is high. It expects busy to return in the next cycle and a complete second frame of transactions to follow without a gap. The bench also pulses start in the middle of a running frame, where it must be ignored. Against a per-clock reference built from queues of expected reads, cone launches and writes, either kind of mishandling shows up as a busy or done mismatch, or as an extra or missing transaction.

// File: rtl/cone_pkg.sv
package cone_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_NEXT, ST_FETCH, ST_CONES, ST_WRITE
  } ctrl_state_e;

  typedef enum logic [1:0] {
    SQ_IDLE, SQ_LAUNCH, SQ_WAIT
  } seq_state_e;

  // 1-based identifier of the cone at level lvl, position pos (both 0-based)
  function automatic int cone_id(input int h, input int lvl, input int pos);
    int base;
    base = 0;
    for (int k = 0; k < lvl; k++) base += h - k;
    return base + pos + 1;
  endfunction

  // level of the idx-th cone in execution order
  function automatic int order_lvl(input int h, input int idx);
    int n;
    int res;
    n = 0;
    res = 0;
    for (int j = 0; j < h; j++)
      for (int l = 0; l <= j; l++) begin
        if (n == idx) res = l;
        n++;
      end
    return res;
  endfunction

  // position of the idx-th cone in execution order
  function automatic int order_pos(input int h, input int idx);
    int n;
    int res;
    n = 0;
    res = 0;
    for (int j = 0; j < h; j++)
      for (int l = 0; l <= j; l++) begin
        if (n == idx) res = j - l;
        n++;
      end
    return res;
  endfunction

endpackage

// File: rtl/cone_win_scan.sv
module cone_win_scan #(
  parameter int FRAME_W = 20,
  parameter int FRAME_H = 12,
  parameter int WIN     = 8,
  parameter int CW      = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          adv,
  output logic [CW-1:0] x0,
  output logic [CW-1:0] y0,
  output logic [CW-1:0] wcols,
  output logic [CW-1:0] wrows,
  output logic          last
);

  logic row_end;
  logic col_end;

  assign row_end = (int'(x0) + WIN >= FRAME_W);
  assign col_end = (int'(y0) + WIN >= FRAME_H);
  assign last    = row_end && col_end;
  assign wcols   = row_end ? CW'(FRAME_W - int'(x0)) : CW'(WIN);
  assign wrows   = col_end ? CW'(FRAME_H - int'(y0)) : CW'(WIN);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      x0 <= '0;
      y0 <= '0;
    end else if (adv) begin
      if (row_end) begin
        x0 <= '0;
        y0 <= y0 + CW'(WIN);
      end else begin
        x0 <= x0 + CW'(WIN);
      end
    end
  end

  // R3
  origin_range_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(x0) < FRAME_W) && (int'(y0) < FRAME_H));

endmodule

// File: rtl/cone_xfer_agu.sv
module cone_xfer_agu #(
  parameter int FRAME_W    = 20,
  parameter int FRAME_H    = 12,
  parameter int WIN        = 8,
  parameter int HALO       = 2,
  parameter int IN_BASE    = 0,
  parameter int OUT_BASE   = 1024,
  parameter int SLOT_WORDS = 144,
  parameter int TOP_SLOT   = 6,
  parameter int AW         = 16,
  parameter int BAW        = 10,
  parameter int CW         = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           kick,
  input  logic           kick_wr,
  input  logic [CW-1:0]  x0,
  input  logic [CW-1:0]  y0,
  input  logic [CW-1:0]  wcols,
  input  logic [CW-1:0]  wrows,
  input  logic           mem_gnt,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic           buf_we,
  output logic           buf_re,
  output logic [BAW-1:0] buf_addr,
  output logic           xfer_done
);

  localparam int IN_SIDE = WIN + 2 * HALO;

  logic [CW-1:0] ox, oy, ncols, nrows;
  logic [CW-1:0] r, c, nr, nc;
  logic          last_beat;

  function automatic logic [AW-1:0] ext_addr(input logic wr, input int bx,
                                             input int by, input int rr, input int cc);
    int gx;
    int gy;
    if (wr) begin
      gx = bx + cc;
      gy = by + rr;
      return AW'(OUT_BASE + gy * FRAME_W + gx);
    end
    gx = bx - HALO + cc;
    gy = by - HALO + rr;
    if (gx < 0) gx = 0;
    else if (gx > FRAME_W - 1) gx = FRAME_W - 1;
    if (gy < 0) gy = 0;
    else if (gy > FRAME_H - 1) gy = FRAME_H - 1;
    return AW'(IN_BASE + gy * FRAME_W + gx);
  endfunction

  function automatic logic [BAW-1:0] local_addr(input logic wr, input int rr, input int cc);
    if (wr) return BAW'(TOP_SLOT * SLOT_WORDS + rr * WIN + cc);
    return BAW'(rr * IN_SIDE + cc);
  endfunction

  assign last_beat = (c == ncols - CW'(1)) && (r == nrows - CW'(1));
  assign xfer_done = mem_req & mem_gnt & last_beat;
  assign buf_we    = mem_req & mem_gnt & ~mem_we;
  assign buf_re    = mem_req & mem_we;

  always_comb begin
    nc = c + CW'(1);
    nr = r;
    if (c == ncols - CW'(1)) begin
      nc = '0;
      nr = r + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req  <= 1'b0;
      mem_we   <= 1'b0;
      mem_addr <= '0;
      buf_addr <= '0;
      ox       <= '0;
      oy       <= '0;
      ncols    <= '0;
      nrows    <= '0;
      r        <= '0;
      c        <= '0;
    end else if (kick) begin
      ox       <= x0;
      oy       <= y0;
      r        <= '0;
      c        <= '0;
      ncols    <= kick_wr ? wcols : CW'(IN_SIDE);
      nrows    <= kick_wr ? wrows : CW'(IN_SIDE);
      mem_req  <= 1'b1;
      mem_we   <= kick_wr;
      mem_addr <= ext_addr(kick_wr, int'(x0), int'(y0), 0, 0);
      buf_addr <= local_addr(kick_wr, 0, 0);
    end else if (mem_req && mem_gnt) begin
      if (last_beat) begin
        mem_req <= 1'b0;
      end else begin
        r        <= nr;
        c        <= nc;
        mem_addr <= ext_addr(mem_we, int'(ox), int'(oy), int'(nr), int'(nc));
        buf_addr <= local_addr(mem_we, int'(nr), int'(nc));
      end
    end
  end

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R9
  wr_range_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> ((int'(mem_addr) >= OUT_BASE) &&
                             (int'(mem_addr) < OUT_BASE + FRAME_W * FRAME_H)));

endmodule

// File: rtl/cone_tree_seq.sv
module cone_tree_seq
  import cone_pkg::*;
#(
  parameter int H          = 3,
  parameter int NC         = 6,
  parameter int SLOT_WORDS = 144,
  parameter int LEAF_OFS   = 2,
  parameter int BAW        = 10
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           go,
  input  logic [NC-1:0]  cone_done,
  output logic [NC-1:0]  cone_start,
  output logic [NC-1:0]  cone_busy,
  output logic [BAW-1:0] src0_addr,
  output logic [BAW-1:0] src1_addr,
  output logic [BAW-1:0] dst_addr,
  output logic           seq_done
);

  localparam int ID_W = $clog2(NC + 1);
  localparam int IW   = (NC > 1) ? $clog2(NC) : 1;

  logic [ID_W-1:0] rom_id [NC];
  logic [ID_W-1:0] rom_c0 [NC];
  logic [ID_W-1:0] rom_c1 [NC];
  logic [BAW-1:0]  rom_s0 [NC];
  logic [BAW-1:0]  rom_s1 [NC];

  // schedule ROM: cone identifier, children slots and buffer regions per step
  for (genvar i = 0; i < NC; i++) begin : g_rom
    localparam int L  = order_lvl(H, i);
    localparam int P  = order_pos(H, i);
    localparam int ID = cone_id(H, L, P);
    localparam int C0 = (L == 0) ? 0 : cone_id(H, L - 1, P);
    localparam int C1 = (L == 0) ? 0 : cone_id(H, L - 1, P + 1);
    assign rom_id[i] = ID_W'(ID);
    assign rom_c0[i] = ID_W'(C0);
    assign rom_c1[i] = ID_W'(C1);
    assign rom_s0[i] = BAW'((L == 0) ? P * LEAF_OFS : C0 * SLOT_WORDS);
    assign rom_s1[i] = BAW'((L == 0) ? P * LEAF_OFS : C1 * SLOT_WORDS);
  end

  seq_state_e      sq;
  logic [IW-1:0]   idx;
  logic [NC:0]     ready_mask;
  logic [ID_W-1:0] cur_id;
  logic [NC-1:0]   sel_oh;
  logic            kids_ready;
  logic            done_hit;

  assign cur_id     = rom_id[idx];
  assign sel_oh     = NC'(1) << (cur_id - ID_W'(1));
  assign kids_ready = ready_mask[rom_c0[idx]] && ready_mask[rom_c1[idx]];
  assign done_hit   = |(cone_done & sel_oh);
  assign seq_done   = (sq == SQ_WAIT) && done_hit && (idx == IW'(NC - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sq         <= SQ_IDLE;
      idx        <= '0;
      ready_mask <= '0;
      cone_start <= '0;
      cone_busy  <= '0;
      src0_addr  <= '0;
      src1_addr  <= '0;
      dst_addr   <= '0;
    end else begin
      cone_start <= '0;
      case (sq)
        SQ_IDLE: if (go) begin
          idx        <= '0;
          ready_mask <= (NC + 1)'(1);
          sq         <= SQ_LAUNCH;
        end
        SQ_LAUNCH: if (kids_ready) begin
          cone_start <= sel_oh;
          cone_busy  <= sel_oh;
          src0_addr  <= rom_s0[idx];
          src1_addr  <= rom_s1[idx];
          dst_addr   <= BAW'(int'(cur_id) * SLOT_WORDS);
          sq         <= SQ_WAIT;
        end
        SQ_WAIT: if (done_hit) begin
          cone_busy  <= '0;
          ready_mask <= ready_mask | {sel_oh, 1'b0};
          if (idx == IW'(NC - 1)) begin
            sq <= SQ_IDLE;
          end else begin
            idx <= idx + IW'(1);
            sq  <= SQ_LAUNCH;
          end
        end
        default: sq <= SQ_IDLE;
      endcase
    end
  end

  // R6
  one_start_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cone_start));

  // R6
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (|cone_start) |=> !(|cone_start));

  // R11
  busy_one_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cone_busy));

  // R11
  busy_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (|cone_start) |-> (cone_busy == cone_start));

endmodule

// File: rtl/cone_tree_ctrl.sv
module cone_tree_ctrl
  import cone_pkg::*;
#(
  parameter int FRAME_W    = 20,
  parameter int FRAME_H    = 12,
  parameter int WIN        = 8,
  parameter int HALO       = 2,
  parameter int N_ITER     = 12,
  parameter int CONE_DEPTH = 4,
  parameter int LEAF_OFS   = 2,
  parameter int IN_BASE    = 0,
  parameter int OUT_BASE   = 1024,
  parameter int AW         = 16,
  parameter int BAW        = 10,
  parameter int CW         = 8,
  parameter int NUM_CONES  = (N_ITER / CONE_DEPTH) * (N_ITER / CONE_DEPTH + 1) / 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  output logic                 busy,
  output logic                 done,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [AW-1:0]        mem_addr,
  input  logic                 mem_gnt,
  output logic                 buf_we,
  output logic                 buf_re,
  output logic [BAW-1:0]       buf_addr,
  output logic [NUM_CONES-1:0] cone_start,
  output logic [NUM_CONES-1:0] cone_busy,
  input  logic [NUM_CONES-1:0] cone_done,
  output logic [BAW-1:0]       cone_src0_addr,
  output logic [BAW-1:0]       cone_src1_addr,
  output logic [BAW-1:0]       cone_dst_addr
);

  localparam int LEVELS     = N_ITER / CONE_DEPTH;
  localparam int IN_SIDE    = WIN + 2 * HALO;
  localparam int SLOT_WORDS = IN_SIDE * IN_SIDE;

  ctrl_state_e   st;
  logic [CW-1:0] x0, y0, wcols, wrows;
  logic          scan_last, scan_clr, scan_adv;
  logic          kick, kick_wr, xfer_done;
  logic          seq_go, seq_done;

  assign scan_clr = (st == ST_IDLE) && start;
  assign scan_adv = (st == ST_WRITE) && xfer_done && !scan_last;
  assign kick     = (st == ST_NEXT) || ((st == ST_CONES) && seq_done);
  assign kick_wr  = (st == ST_CONES);
  assign seq_go   = (st == ST_FETCH) && xfer_done;

  cone_win_scan #(
    .FRAME_W(FRAME_W), .FRAME_H(FRAME_H), .WIN(WIN), .CW(CW)
  ) scan_i (
    .clk(clk), .rst(rst), .clr(scan_clr), .adv(scan_adv),
    .x0(x0), .y0(y0), .wcols(wcols), .wrows(wrows), .last(scan_last)
  );

  cone_xfer_agu #(
    .FRAME_W(FRAME_W), .FRAME_H(FRAME_H), .WIN(WIN), .HALO(HALO),
    .IN_BASE(IN_BASE), .OUT_BASE(OUT_BASE), .SLOT_WORDS(SLOT_WORDS),
    .TOP_SLOT(NUM_CONES), .AW(AW), .BAW(BAW), .CW(CW)
  ) agu_i (
    .clk(clk), .rst(rst), .kick(kick), .kick_wr(kick_wr),
    .x0(x0), .y0(y0), .wcols(wcols), .wrows(wrows), .mem_gnt(mem_gnt),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .buf_we(buf_we), .buf_re(buf_re), .buf_addr(buf_addr), .xfer_done(xfer_done)
  );

  cone_tree_seq #(
    .H(LEVELS), .NC(NUM_CONES), .SLOT_WORDS(SLOT_WORDS),
    .LEAF_OFS(LEAF_OFS), .BAW(BAW)
  ) seq_i (
    .clk(clk), .rst(rst), .go(seq_go), .cone_done(cone_done),
    .cone_start(cone_start), .cone_busy(cone_busy),
    .src0_addr(cone_src0_addr), .src1_addr(cone_src1_addr),
    .dst_addr(cone_dst_addr), .seq_done(seq_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          busy <= 1'b1;
          st   <= ST_NEXT;
        end
        ST_NEXT:  st <= ST_FETCH;
        ST_FETCH: if (xfer_done) st <= ST_CONES;
        ST_CONES: if (seq_done) st <= ST_WRITE;
        ST_WRITE: if (xfer_done) begin
          if (scan_last) begin
            st   <= ST_IDLE;
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            st <= ST_NEXT;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !mem_req));

  // R6
  cone_vs_mem_chk: assert property (@(posedge clk) disable iff (rst)
    (|cone_start) |-> !mem_req);

  // R2
  busy_activity_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req || (|cone_busy)) |-> busy);

endmodule

// File: tb/cone_tree_ctrl_tb_top.sv
module cone_tree_ctrl_tb_top;

  localparam int FW = 20, FH = 12, WIN = 8, HALO = 2, NIT = 12, DEP = 4;
  localparam int LOFS = 2, INB = 0, OUTB = 1024, AW = 16, BAW = 10, CW = 8;
  localparam int NC = 6, SIDE = WIN + 2 * HALO, SLOTW = SIDE * SIDE;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic mem_gnt = 1'b0;
  logic [NC-1:0] cone_done = '0;
  logic busy, done, mem_req, mem_we, buf_we, buf_re;
  logic [AW-1:0] mem_addr;
  logic [BAW-1:0] buf_addr, s0a, s1a, dsa;
  logic [NC-1:0] cone_start, cone_busy;

  always #2 clk = ~clk;

  cone_tree_ctrl #(
    .FRAME_W(FW), .FRAME_H(FH), .WIN(WIN), .HALO(HALO), .N_ITER(NIT),
    .CONE_DEPTH(DEP), .LEAF_OFS(LOFS), .IN_BASE(INB), .OUT_BASE(OUTB),
    .AW(AW), .BAW(BAW), .CW(CW)
  ) dut_i (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
    .buf_we(buf_we), .buf_re(buf_re), .buf_addr(buf_addr),
    .cone_start(cone_start), .cone_busy(cone_busy), .cone_done(cone_done),
    .cone_src0_addr(s0a), .cone_src1_addr(s1a), .cone_dst_addr(dsa)
  );

  typedef struct {
    int kind;   // 0 read, 1 write, 2 cone launch
    int addr;
    int baddr;
    int id;
    int s0;
    int s1;
    int d;
  } ev_t;

  ev_t q[$];
  int errors = 0, checks = 0, cyc = 0;
  int kid0[7], kid1[7], lpos[7];
  int order[6] = '{1, 2, 4, 3, 5, 6};
  bit monitor_on = 0, finished = 0;
  bit exp_busy = 0, exp_done = 0;
  int exp_cb = 0;
  bit prev_pend = 0, prev_we = 0;
  int prev_addr = 0;
  int bmask = 0, frames_done = 0, frame_writes = 0;
  int gnt_mode = 0;
  logic [7:0] lf = 8'h5a;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int clampi(input int v, input int lo, input int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  task automatic build_frame();
    ev_t e;
    for (int wy = 0; wy < FH; wy += WIN)
      for (int wx = 0; wx < FW; wx += WIN) begin
        int w, h;
        for (int r = 0; r < SIDE; r++)
          for (int c = 0; c < SIDE; c++) begin
            e = '{0, INB + clampi(wy - HALO + r, 0, FH - 1) * FW + clampi(wx - HALO + c, 0, FW - 1),
                  r * SIDE + c, 0, 0, 0, 0};
            q.push_back(e);
          end
        for (int k = 0; k < NC; k++) begin
          int id;
          id = order[k];
          e = '{2, 0, 0, id, 0, 0, id * SLOTW};
          if (kid0[id] == 0) begin
            e.s0 = lpos[id] * LOFS;
            e.s1 = lpos[id] * LOFS;
          end else begin
            e.s0 = kid0[id] * SLOTW;
            e.s1 = kid1[id] * SLOTW;
          end
          q.push_back(e);
        end
        w = (FW - wx < WIN) ? FW - wx : WIN;
        h = (FH - wy < WIN) ? FH - wy : WIN;
        for (int r = 0; r < h; r++)
          for (int c = 0; c < w; c++) begin
            e = '{1, OUTB + (wy + r) * FW + wx + c, NC * SLOTW + r * WIN + c, 0, 0, 0, 0};
            q.push_back(e);
          end
      end
  endtask

  // reference model, compared in the middle of every cycle
  always @(negedge clk) begin
    if (monitor_on && !finished) begin
      bit nb, nd;
      int cb_now;
      ev_t e;
      nb = exp_busy;
      nd = 1'b0;
      chk(busy == exp_busy, "R2 busy", busy, exp_busy);
      chk(done == exp_done, "R10 done", done, exp_done);
      cb_now = exp_cb | int'(cone_start);
      chk(int'(cone_busy) == cb_now, "R11 cone_busy", cone_busy, cb_now);
      if (prev_pend) begin
        chk(mem_req == 1'b1, "R5 req held", mem_req, 1);
        chk(int'(mem_addr) == prev_addr, "R5 addr stable", mem_addr, prev_addr);
        chk(mem_we == prev_we, "R5 we stable", mem_we, prev_we);
      end
      if (cone_start != '0) begin
        chk($countones(cone_start) == 1, "R6 onehot start", cone_start, 1);
        chk(!mem_req, "R6 no start during transfer", mem_req, 0);
        if (q.size() == 0) chk(0, "R6 unexpected cone start", cone_start, 0);
        else begin
          e = q.pop_front();
          chk(e.kind == 2, "R6 order kind", 2, e.kind);
          chk(int'(cone_start) == (1 << (e.id - 1)), "R6 order id", cone_start, 1 << (e.id - 1));
          chk(int'(s0a) == e.s0, "R8 src0", s0a, e.s0);
          chk(int'(s1a) == e.s1, "R8 src1", s1a, e.s1);
          chk(int'(dsa) == e.d, "R8 dst", dsa, e.d);
          if (kid0[e.id] != 0)
            chk(bmask[kid0[e.id]] && bmask[kid1[e.id]], "R7 children done", bmask, e.id);
        end
      end
      if (mem_req && mem_gnt) begin
        if (q.size() == 0) chk(0, "R4 unexpected transfer", mem_addr, 0);
        else begin
          e = q.pop_front();
          chk(int'(mem_we) == e.kind, "R4 transfer kind", mem_we, e.kind);
          chk(int'(mem_addr) == e.addr, e.kind == 1 ? "R9 write addr" : "R4 read addr", mem_addr, e.addr);
          chk(int'(buf_addr) == e.baddr, e.kind == 1 ? "R9 buf addr" : "R4 buf addr", buf_addr, e.baddr);
          chk(buf_we == (e.kind == 0), "R4 buf_we", buf_we, e.kind == 0);
          chk(buf_re == (e.kind == 1), "R9 buf_re", buf_re, e.kind == 1);
          if (e.kind == 0 && e.baddr == 0) bmask = 0;
          if (e.kind == 1) begin
            frame_writes++;
            if (q.size() == 0) begin
              nb = 1'b0;
              nd = 1'b1;
              frames_done++;
              chk(frame_writes == FW * FH, "R3 pixels written once", frame_writes, FW * FH);
            end
          end
        end
      end
      if (start && !busy) begin
        nb = 1'b1;
        frame_writes = 0;
        build_frame();
      end
      bmask = bmask | (int'(cone_done) << 1);
      exp_cb = cb_now & ~int'(cone_done);
      prev_pend = mem_req && !mem_gnt;
      prev_addr = int'(mem_addr);
      prev_we = mem_we;
      exp_busy = nb;
      exp_done = nd;
    end
  end

  // memory grant driver
  always @(posedge clk) begin
    #1;
    lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    case (gnt_mode)
      0: mem_gnt <= lf[0];
      1: mem_gnt <= 1'b1;
      default: mem_gnt <= (cyc % 3 != 0);
    endcase
  end

  // cone slot responders with varying latency
  int cd_cnt = 0, cd_id = 0, lat_seed = 0;
  always @(posedge clk) begin
    #1;
    cone_done <= '0;
    if (cd_cnt > 0) begin
      cd_cnt--;
      if (cd_cnt == 0) cone_done[cd_id] <= 1'b1;
    end
    if (cone_start != '0) begin
      for (int k = 0; k < NC; k++) if (cone_start[k]) cd_id = k;
      lat_seed++;
      cd_cnt = 1 + (lat_seed % 4);
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
      finish_run();
    end
  end

  task automatic wait_done();
    do begin
      @(posedge clk);
      #1;
    end while (!done);
  endtask

  initial begin
    for (int i = 0; i < 7; i++) begin
      kid0[i] = 0;
      kid1[i] = 0;
      lpos[i] = 0;
    end
    kid0[4] = 1; kid1[4] = 2;
    kid0[5] = 2; kid1[5] = 3;
    kid0[6] = 4; kid1[6] = 5;
    lpos[1] = 0; lpos[2] = 1; lpos[3] = 2;

    // R1: outputs quiet during and after reset
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy && !done && !mem_req, "R1 reset outputs", {busy, done, mem_req}, 0);
    chk(cone_start == '0 && cone_busy == '0, "R1 reset cones", {cone_start, cone_busy}, 0);
    @(posedge clk);
    #1 rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(!busy && !done && !mem_req, "R1 idle after reset", {busy, done, mem_req}, 0);
    chk(cone_start == '0 && cone_busy == '0, "R1 idle cones", {cone_start, cone_busy}, 0);
    monitor_on = 1;

    // frame 1: irregular grants, a start in mid-frame that must be ignored (R2)
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    repeat (300) @(posedge clk);
    #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    wait_done();

    // frame 2: started in the done cycle itself (R10 and R2 together), full grants
    gnt_mode = 1;
    start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    wait_done();

    // frame 3: periodic stalls, start after an idle gap
    gnt_mode = 2;
    repeat (10) @(posedge clk);
    #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    wait_done();
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk(q.size() == 0, "R3 all windows issued", q.size(), 0);
    chk(frames_done == 3, "R2 frame count", frames_done, 3);
    chk(!busy && !done, "R10 idle at end", {busy, done}, 0);
    finish_run();
  end

endmodule